// File: doc/BRIEF.md
# SMI Event Generation Controller

This block collects system-management event sources, holds each one in a sticky status bit, and masks each with its own enable bit. It drives an active-low SMI# line whenever at least one enabled status bit is pending and the controller is armed. Software reaches three 32-bit registers through a simple register port with address, write data and byte strobes. One register holds the enables, one holds the status bits, and one holds the end-of-SMI flag.

The end-of-SMI flag is set on the same clock edge that pulls SMI# low, and SMI# follows it. Software rearms the controller by writing 1 to that flag. The write releases SMI# at once and opens a blanking window of `BLANK_CYCLES` clocks. During that window SMI# cannot assert again, even if enabled status is still pending.

All state sits in the standby domain and is cleared only by the standby reset input. That input is applied asynchronously and released through a two-stage synchronizer.

Top module: `smi_event_ctrl`

## Requirements
- R1: While the standby reset is applied, and after it is released, the enable bits, status bits and end-of-SMI flag are all 0. Every register reads 0 and `smi_n` is 1.
- R2: Address 0 holds the enable bits in data bits [NUM_SRC-1:0], which are readable and writable. Data bits above them read 0.
- R3: A one-cycle pulse on `evt_pulse[i]` sets status bit i at address 1, in data bit i, on that clock edge. The bit then stays set. Writing 1 to it clears it, and writing 0 leaves it unchanged.
- R4: If an event pulse and a write of 1 to the same status bit occur in the same cycle, the status bit ends up set.
- R5: When a status bit and its enable bit are both 1, the end-of-SMI flag is 0 and no blanking is running, `smi_n` goes low on the next clock edge. A status bit whose enable is 0 never drives `smi_n` low.
- R6: The end-of-SMI flag reads at address 2, data bit 16, and is 1 exactly while `smi_n` is low. `smi_n` stays low until a write of 1 to that bit. A write of 0, or clearing the status bits, does not release it.
- R7: A write of 1 to the end-of-SMI bit clears the flag and drives `smi_n` high on that edge. It also starts the blanking window. If enabled status is still pending, `smi_n` goes low again on the (BLANK_CYCLES+1)-th edge after the write. A further end-of-SMI write during blanking restarts the window.
- R8: A register write takes effect only in byte lanes whose strobe is 1. With `reg_be[0]`=0, enable and status bits are untouched. With `reg_be[2]`=0, the end-of-SMI flag is untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock |
| sb_rst_n | input | 1 | Standby reset, active low, asynchronous assert |
| reg_addr | input | 2 | Register select: 0 enable, 1 status, 2 control |
| reg_wr | input | 1 | Write strobe for one cycle |
| reg_wdata | input | 32 | Write data |
| reg_be | input | 4 | Byte lane strobes for the write |
| reg_rdata | output | 32 | Read data of the selected register (combinational) |
| evt_pulse | input | NUM_SRC | One-cycle event pulses, one per source |
| smi_n | output | 1 | System management interrupt, active low |

## Verification
The bench uses the default build: six sources and a four-clock blanking window. With six sources, all 64 enable masks can be swept against every single-source event, so each enable-to-status gating path is checked in both polarities. The short window lets the bench count, edge by edge, the exact cycle in which SMI# returns, including when the window is restarted part-way through. Those settings also bring the same-cycle set/clear collision, the masked byte-lane writes and a standby reset taken while SMI# is low within reach.

// File: rtl/smi_pkg.sv
package smi_pkg;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned BE_W    = DATA_W / 8;
  localparam int unsigned ADDR_W  = 2;
  localparam int unsigned EOS_BIT = 16;
  localparam int unsigned EOS_LANE = EOS_BIT / 8;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_EN  = 2'd0,
    ADDR_STS = 2'd1,
    ADDR_CTL = 2'd2,
    ADDR_RSV = 2'd3
  } smi_addr_e;
endpackage

// File: rtl/smi_rst_sync.sv
module smi_rst_sync (
  input  logic clk,
  input  logic rst_in_n,
  output logic rst_out_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_in_n) begin
    if (!rst_in_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_out_n = sync_q[1];
endmodule

// File: rtl/smi_enable_reg.sv
module smi_enable_reg #(
  parameter int unsigned NUM_SRC = 6,
  localparam int unsigned LANES  = (NUM_SRC + 7) / 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_sel,
  input  logic [NUM_SRC-1:0] wdata,
  input  logic [LANES-1:0]   be,
  output logic [NUM_SRC-1:0] en_q
);
  logic [NUM_SRC-1:0] bit_we;
  logic [NUM_SRC-1:0] en_d;

  // per-bit write enable from the byte lane that carries the bit
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    assign bit_we[i] = wr_sel & be[i/8];
  end

  always_comb begin
    en_d = (en_q & ~bit_we) | (wdata & bit_we);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (|bit_we) begin
      en_q <= en_d;
    end
  end
endmodule

// File: rtl/smi_status_reg.sv
module smi_status_reg #(
  parameter int unsigned NUM_SRC = 6,
  localparam int unsigned LANES  = (NUM_SRC + 7) / 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] evt,
  input  logic               clr_sel,
  input  logic [NUM_SRC-1:0] wdata,
  input  logic [LANES-1:0]   be,
  output logic [NUM_SRC-1:0] sts_q
);
  logic [NUM_SRC-1:0] clr_bits;
  logic [NUM_SRC-1:0] sts_d;
  logic               sts_ce;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_clr
    assign clr_bits[i] = clr_sel & be[i/8] & wdata[i];
  end

  // an arriving event takes priority over a clear of the same bit
  always_comb begin
    sts_d  = (sts_q & ~clr_bits) | evt;
    sts_ce = (|clr_bits) | (|evt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q <= '0;
    end else if (sts_ce) begin
      sts_q <= sts_d;
    end
  end
endmodule

// File: rtl/smi_rearm.sv
module smi_rearm #(
  parameter int unsigned BLANK_CYCLES = 4,
  localparam int unsigned CNT_W = $clog2(BLANK_CYCLES + 2)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic eos_w1c,
  input  logic cause,
  output logic eos_q
);
  logic [CNT_W-1:0] blank_q;
  logic [CNT_W-1:0] blank_d;
  logic             eos_d;
  logic             blank_idle;

  assign blank_idle = (blank_q == '0);

  always_comb begin
    if (eos_w1c) begin
      eos_d   = 1'b0;
      blank_d = CNT_W'(BLANK_CYCLES);
    end else begin
      eos_d   = eos_q | (cause & blank_idle);
      blank_d = blank_idle ? blank_q : blank_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eos_q   <= 1'b0;
      blank_q <= '0;
    end else begin
      eos_q   <= eos_d;
      blank_q <= blank_d;
    end
  end
endmodule

// File: rtl/smi_event_ctrl.sv
module smi_event_ctrl
  import smi_pkg::*;
#(
  parameter int unsigned NUM_SRC      = 6,
  parameter int unsigned BLANK_CYCLES = 4,
  localparam int unsigned LANES       = (NUM_SRC + 7) / 8
) (
  input  logic               clk,
  input  logic               sb_rst_n,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic               reg_wr,
  input  logic [DATA_W-1:0]  reg_wdata,
  input  logic [BE_W-1:0]    reg_be,
  output logic [DATA_W-1:0]  reg_rdata,
  input  logic [NUM_SRC-1:0] evt_pulse,
  output logic               smi_n
);
  logic               rst_n_sync;
  logic [NUM_SRC-1:0] en_q;
  logic [NUM_SRC-1:0] sts_q;
  logic               eos_q;
  logic               wr_en_sel;
  logic               wr_sts_sel;
  logic               eos_w1c;
  logic               unused_wdata;

  smi_rst_sync u_rst_sync (
    .clk       (clk),
    .rst_in_n  (sb_rst_n),
    .rst_out_n (rst_n_sync)
  );

  // write decode
  assign wr_en_sel  = reg_wr && (reg_addr == ADDR_EN);
  assign wr_sts_sel = reg_wr && (reg_addr == ADDR_STS);
  assign eos_w1c    = reg_wr && (reg_addr == ADDR_CTL) && reg_be[EOS_LANE] && reg_wdata[EOS_BIT];
  assign unused_wdata = ^reg_wdata;

  smi_enable_reg #(.NUM_SRC(NUM_SRC)) u_en (
    .clk    (clk),
    .rst_n  (rst_n_sync),
    .wr_sel (wr_en_sel),
    .wdata  (reg_wdata[NUM_SRC-1:0]),
    .be     (reg_be[LANES-1:0]),
    .en_q   (en_q)
  );

  smi_status_reg #(.NUM_SRC(NUM_SRC)) u_sts (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .evt     (evt_pulse),
    .clr_sel (wr_sts_sel),
    .wdata   (reg_wdata[NUM_SRC-1:0]),
    .be      (reg_be[LANES-1:0]),
    .sts_q   (sts_q)
  );

  smi_rearm #(.BLANK_CYCLES(BLANK_CYCLES)) u_rearm (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .eos_w1c (eos_w1c),
    .cause   (|(sts_q & en_q)),
    .eos_q   (eos_q)
  );

  // read mux
  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      ADDR_EN:  reg_rdata[NUM_SRC-1:0] = en_q;
      ADDR_STS: reg_rdata[NUM_SRC-1:0] = sts_q;
      ADDR_CTL: reg_rdata[EOS_BIT]     = eos_q;
      default:  reg_rdata = '0;
    endcase
  end

  assign smi_n = ~eos_q;
endmodule

// File: rtl/smi_event_ctrl_chk.sv
module smi_event_ctrl_chk
  import smi_pkg::*;
#(
  parameter int unsigned NUM_SRC = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic [ADDR_W-1:0]  reg_addr,
  input logic               reg_wr,
  input logic [DATA_W-1:0]  reg_wdata,
  input logic [BE_W-1:0]    reg_be,
  input logic [NUM_SRC-1:0] evt_pulse,
  input logic               smi_n,
  input logic [NUM_SRC-1:0] en_q,
  input logic [NUM_SRC-1:0] sts_q
);
  logic eos_clr_wr;
  logic sts_clr_wr;
  logic en_wr;
  logic unused_chk;

  assign eos_clr_wr = reg_wr && (reg_addr == ADDR_CTL) && reg_be[EOS_LANE] && reg_wdata[EOS_BIT];
  assign sts_clr_wr = reg_wr && (reg_addr == ADDR_STS) && reg_be[0];
  assign en_wr      = reg_wr && (reg_addr == ADDR_EN) && reg_be[0];
  assign unused_chk = ^{reg_be, reg_wdata};

  AST_SMI_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(smi_n) |-> $past(|(sts_q & en_q))); // R5

  AST_SMI_HELD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!smi_n && !eos_clr_wr) |=> !smi_n); // R6

  AST_EOS_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (!smi_n && eos_clr_wr) |=> smi_n); // R7

  AST_BLANK_AFTER_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(smi_n) |=> smi_n); // R7

  AST_STS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !sts_clr_wr |=> ((sts_q & $past(sts_q)) == $past(sts_q))); // R3

  AST_EVT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_pulse) |=> ((sts_q & $past(evt_pulse)) == $past(evt_pulse))); // R4

  AST_EN_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
    !en_wr |=> $stable(en_q)); // R8
endmodule

bind smi_event_ctrl smi_event_ctrl_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n_sync),
  .reg_addr  (reg_addr),
  .reg_wr    (reg_wr),
  .reg_wdata (reg_wdata),
  .reg_be    (reg_be),
  .evt_pulse (evt_pulse),
  .smi_n     (smi_n),
  .en_q      (en_q),
  .sts_q     (sts_q)
);

// File: tb/smi_event_ctrl_tb_top.sv
`timescale 1ns/1ps
module smi_event_ctrl_tb_top;
  localparam int NSRC  = 6;
  localparam int BLANK = 4;
  localparam logic [31:0] EOS = 32'h1 << 16;
  localparam logic [31:0] ALL = (32'h1 << NSRC) - 1;

  logic            clk = 1'b0;
  logic            sb_rst_n = 1'b0;
  logic [1:0]      reg_addr = 2'd0;
  logic            reg_wr = 1'b0;
  logic [31:0]     reg_wdata = '0;
  logic [3:0]      reg_be = '0;
  logic [31:0]     reg_rdata;
  logic [NSRC-1:0] evt_pulse = '0;
  logic            smi_n;

  int n_checks = 0;
  int n_fail   = 0;

  always #2.5 clk = ~clk;

  smi_event_ctrl #(.NUM_SRC(NSRC), .BLANK_CYCLES(BLANK)) dut_i (
    .clk(clk), .sb_rst_n(sb_rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_be(reg_be), .reg_rdata(reg_rdata),
    .evt_pulse(evt_pulse), .smi_n(smi_n)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d, input logic [3:0] b);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_be = b; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_be = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic pulse(input logic [NSRC-1:0] m);
    @(negedge clk);
    evt_pulse = m;
    @(negedge clk);
    evt_pulse = '0;
  endtask

  task automatic cleanup();
    wr(2'd1, ALL, 4'hF);
    wr(2'd2, EOS, 4'h4);
    repeat (BLANK + 1) @(negedge clk);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #500000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual=%h expected=%h", 32'h1, 32'h0);
    summary();
  end

  initial begin
    logic [31:0] d;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(smi_n === 1'b1, "R1 smi_n in reset", {31'h0, smi_n}, 32'h1);
    sb_rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(smi_n === 1'b1, "R1 smi_n after reset", {31'h0, smi_n}, 32'h1);
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], d);
      chk(d === 32'h0, "R1 register reads 0", d, 32'h0);
    end

    // R2: enable width, upper bits read 0
    wr(2'd0, 32'hFFFF_FFFF, 4'hF);
    rd(2'd0, d);
    chk(d === ALL, "R2 enable readback", d, ALL);
    // R8: write without lane 0 strobe leaves enables
    wr(2'd0, 32'h0, 4'hE);
    rd(2'd0, d);
    chk(d === ALL, "R8 enable lane masked", d, ALL);
    wr(2'd0, 32'h0, 4'hF);

    // R5/R3/R6: sweep all enable masks against each single source
    for (int e = 0; e < 64; e++) begin
      for (int s = 0; s < NSRC; s++) begin
        logic exp_smi;
        exp_smi = ((e >> s) & 1) != 0;
        wr(2'd0, 32'(e), 4'hF);
        pulse(NSRC'(1 << s));
        chk(smi_n === 1'b1, "R5 no SMI before latency", {31'h0, smi_n}, 32'h1);
        @(negedge clk);
        chk(smi_n === !exp_smi, "R5 SMI follows enable gating", {31'h0, smi_n}, {31'h0, !exp_smi});
        rd(2'd1, d);
        chk(d === (32'h1 << s), "R3 status bit set", d, 32'h1 << s);
        rd(2'd2, d);
        chk(d === (exp_smi ? EOS : 32'h0), "R6 end-of-SMI flag", d, exp_smi ? EOS : 32'h0);
        cleanup();
      end
    end

    // R3: write 0 ignored, write 1 clears
    wr(2'd0, 32'h0, 4'hF);
    pulse(6'b101001);
    wr(2'd1, 32'h0, 4'hF);
    rd(2'd1, d);
    chk(d === 32'h29, "R3 write 0 ignored", d, 32'h29);
    wr(2'd1, 32'h08, 4'hF);
    rd(2'd1, d);
    chk(d === 32'h21, "R3 write 1 clears one bit", d, 32'h21);
    // R8: status clear without lane strobe
    wr(2'd1, ALL, 4'hE);
    rd(2'd1, d);
    chk(d === 32'h21, "R8 status lane masked", d, 32'h21);
    // R4: set wins over same-cycle clear
    @(negedge clk);
    reg_addr = 2'd1; reg_wdata = 32'h04; reg_be = 4'hF; reg_wr = 1'b1;
    evt_pulse = 6'b000100;
    @(negedge clk);
    reg_wr = 1'b0; reg_be = '0; evt_pulse = '0;
    rd(2'd1, d);
    chk(d === 32'h25, "R4 event wins over clear", d, 32'h25);
    cleanup();

    // R6/R7: hold and blanking
    wr(2'd0, 32'h1, 4'hF);
    pulse(6'b000001);
    @(negedge clk);
    chk(smi_n === 1'b0, "R6 SMI asserted", {31'h0, smi_n}, 32'h0);
    wr(2'd2, 32'h0, 4'hF);
    chk(smi_n === 1'b0, "R6 write 0 keeps SMI", {31'h0, smi_n}, 32'h0);
    wr(2'd2, EOS, 4'hB);
    chk(smi_n === 1'b0, "R8 end-of-SMI lane masked", {31'h0, smi_n}, 32'h0);
    wr(2'd1, ALL, 4'hF);
    repeat (3) @(negedge clk);
    chk(smi_n === 1'b0, "R6 status clear keeps SMI", {31'h0, smi_n}, 32'h0);
    pulse(6'b000001);
    wr(2'd2, EOS, 4'h4);
    chk(smi_n === 1'b1, "R7 released on write", {31'h0, smi_n}, 32'h1);
    for (int k = 1; k <= BLANK + 1; k++) begin
      @(negedge clk);
      chk(smi_n === (k <= BLANK), "R7 blanking window", {31'h0, smi_n}, {31'h0, k <= BLANK});
    end
    // R7: restart of the window
    wr(2'd2, EOS, 4'h4);
    repeat (2) @(negedge clk);
    wr(2'd2, EOS, 4'h4);
    for (int k = 1; k <= BLANK + 1; k++) begin
      @(negedge clk);
      chk(smi_n === (k <= BLANK), "R7 restarted window", {31'h0, smi_n}, {31'h0, k <= BLANK});
    end

    // R1: standby reset while SMI is low
    chk(smi_n === 1'b0, "R1 SMI low before reset", {31'h0, smi_n}, 32'h0);
    @(negedge clk);
    sb_rst_n = 1'b0;
    #1;
    chk(smi_n === 1'b1, "R1 reset releases SMI", {31'h0, smi_n}, 32'h1);
    for (int a = 0; a < 3; a++) begin
      rd(a[1:0], d);
      chk(d === 32'h0, "R1 registers cleared", d, 32'h0);
    end
    @(negedge clk);
    sb_rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(smi_n === 1'b1, "R1 idle after reset", {31'h0, smi_n}, 32'h1);

    summary();
  end
endmodule